// File: doc/BRIEF.md
# Triple-Copy Majority Strap Reader

This block serves a read-only 32-bit configuration register whose contents are never held in a flip-flop of their own. The value lives in a byte-wide one-time-programmable array as three redundant copies. When a read request arrives, the block walks the array's read port and collects the three copies. It returns their bit-by-bit two-out-of-three vote. A copy damaged by a stray programmed bit or a weak fuse therefore cannot change the returned value.

On the register side the block takes a single access strobe with a write qualifier. It answers reads with a one-cycle valid pulse and a data word, and it raises a busy flag while a fetch is running. On the array side it drives a byte address and takes back the addressed byte in the same cycle, as a combinational array read. Write accesses to the register are accepted and dropped.

Top module: `strap_vote_reader`

## Requirements
- R1: After reset, `busy_o` and `rd_valid_o` are 0, `rd_data_o` is 0 and `arr_addr_o` is 0.
- R2: An accepted read drives `arr_addr_o` through byte addresses 0,1,...,11, one per cycle, starting in the cycle right after the accepting edge. While the block is idle, `arr_addr_o` is 0.
- R3: Copy k (k = 0,1,2) is assembled little-endian from array bytes 4k..4k+3. Byte 4k forms bits 7:0 and byte 4k+3 forms bits 31:24.
- R4: Each bit of `rd_data_o` is the majority of that bit across the three copies: (a&b)|(a&c)|(b&c).
- R5: A read accepted at clock edge t raises `rd_valid_o` for exactly one cycle, the one that follows edge t+12, and `rd_data_o` carries the voted word in that cycle.
- R6: `busy_o` is high from the accepting edge until the last byte is captured. A read request made while `busy_o` is high is ignored: it causes no extra fetch and no extra valid pulse.
- R7: An access with `we_i` = 1 starts no fetch, raises neither `busy_o` nor `rd_valid_o`, and leaves `rd_data_o` unchanged.
- R8: When all three copies are equal, the result equals that copy. When any one copy differs from the other two, at any set of bit positions, the result equals the two that agree.
- R9: While idle, `rd_data_o` holds the last voted word until the next accepted read starts a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Access is a write (ignored) when 1 |
| rd_data_o | output | 32 | Voted strap word |
| rd_valid_o | output | 1 | One-cycle pulse: `rd_data_o` holds a fresh result |
| busy_o | output | 1 | Fetch in progress; new requests are held off |
| arr_addr_o | output | ARR_AW | Fuse array byte address |
| arr_data_i | input | 8 | Byte read from the array at `arr_addr_o` |

## Verification
The vote is exercised with three identical copies and with each copy in turn inverted against the other two. This separates a correct per-bit majority from logic that favours one copy or passes a single copy through. Three mutually distinct copies, whose bits cover all eight a/b/c combinations, separate a true majority from AND or OR reductions. Copies built from distinct ascending bytes expose byte-order and copy-boundary errors. Back-to-back reads, requests made during a fetch and write strobes test the request acceptance logic against the fixed twelve-cycle latency.

// File: rtl/strap_vote_pkg.sv
package strap_vote_pkg;
  localparam int unsigned BYTE_W         = 8;
  localparam int unsigned WORD_W         = 32;
  localparam int unsigned N_COPIES       = 3;
  localparam int unsigned BYTES_PER_WORD = WORD_W / BYTE_W;
  localparam int unsigned N_BYTES        = N_COPIES * BYTES_PER_WORD;
  localparam int unsigned IDX_W          = $clog2(N_BYTES);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/strap_fetch_seq.sv
module strap_fetch_seq
  import strap_vote_pkg::*;
#(
  parameter int unsigned N  = N_BYTES,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic [IW-1:0] idx_o,
  output logic          done_o
);
  logic          busy_q, done_q;
  logic [IW-1:0] idx_q;
  logic          last;

  assign last = (idx_q == IW'(N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_q && last;
      if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;
endmodule

// File: rtl/strap_copy_regs.sv
module strap_copy_regs
  import strap_vote_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cap_en_i,
  input  logic [IDX_W-1:0]             cap_idx_i,
  input  byte_t                        cap_data_i,
  output logic [N_COPIES-1:0][WORD_W-1:0] copies_o
);
  logic [N_BYTES-1:0][BYTE_W-1:0] bytes_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bytes_q <= '0;
    end else if (cap_en_i) begin
      bytes_q[cap_idx_i] <= cap_data_i;
    end
  end

  // lowest address lands in the low byte of each copy
  for (genvar k = 0; k < N_COPIES; k++) begin : g_copy
    assign copies_o[k] = bytes_q[k*BYTES_PER_WORD +: BYTES_PER_WORD];
  end
endmodule

// File: rtl/strap_majority.sv
module strap_majority
  import strap_vote_pkg::*;
(
  input  logic [N_COPIES-1:0][WORD_W-1:0] copies_i,
  output word_t                           vote_o
);
  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    logic [N_COPIES-1:0] col;
    for (genvar k = 0; k < N_COPIES; k++) begin : g_col
      assign col[k] = copies_i[k][b];
    end
    assign vote_o[b] = ($countones(col) > (N_COPIES / 2));
  end
endmodule

// File: rtl/strap_vote_reader.sv
module strap_vote_reader
  import strap_vote_pkg::*;
#(
  parameter int unsigned ARR_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              busy_o,
  output logic [ARR_AW-1:0] arr_addr_o,
  input  logic [BYTE_W-1:0] arr_data_i
);
  logic             busy;
  logic             start;
  logic [IDX_W-1:0] idx;
  logic [N_COPIES-1:0][WORD_W-1:0] copies;

  assign start = req_i && !we_i && !busy;

  strap_fetch_seq #(.N(N_BYTES)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy),
    .idx_o   (idx),
    .done_o  (rd_valid_o)
  );

  strap_copy_regs u_copies (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_en_i   (busy),
    .cap_idx_i  (idx),
    .cap_data_i (arr_data_i),
    .copies_o   (copies)
  );

  strap_majority u_vote (
    .copies_i (copies),
    .vote_o   (rd_data_o)
  );

  assign busy_o     = busy;
  assign arr_addr_o = busy ? ARR_AW'(idx) : '0;
endmodule

// File: rtl/strap_vote_chk.sv
module strap_vote_chk
  import strap_vote_pkg::*;
#(
  parameter int unsigned ARR_AW = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [WORD_W-1:0] rd_data_o,
  input logic              rd_valid_o,
  input logic              busy_o,
  input logic [ARR_AW-1:0] arr_addr_o,
  input logic [BYTE_W-1:0] arr_data_i
);
  logic unused_data;
  assign unused_data = ^arr_data_i;

  p_idle_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> arr_addr_o == '0);

  p_addr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> arr_addr_o == $past(arr_addr_o) + 1'b1);

  p_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && req_i && !we_i |=> busy_o && arr_addr_o == '0);

  p_valid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  p_valid_after_fetch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(busy_o) && !busy_o);

  p_write_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && req_i && we_i |=> !busy_o && !rd_valid_o && $stable(rd_data_o));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !(req_i && !we_i) |=> $stable(rd_data_o));
endmodule

bind strap_vote_reader strap_vote_chk #(.ARR_AW(ARR_AW)) u_chk (.*);

// File: tb/sim_strap_vote_reader.sv
module sim_strap_vote_reader;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [31:0]   rd_data;
  logic          rd_valid;
  logic          busy;
  logic [AW-1:0] arr_addr;
  logic [7:0]    arr_data;
  logic [7:0]    mem [12];

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  int          exp_cyc_q[$];
  int          fetch_pos = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign arr_data = (arr_addr < AW'(12)) ? mem[arr_addr[3:0]] : 8'h5a;

  strap_vote_reader #(.ARR_AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .busy_o(busy),
    .arr_addr_o(arr_addr), .arr_data_i(arr_data)
  );

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] vote(input logic [31:0] a, b, c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic load(input logic [31:0] a, b, c);
    for (int i = 0; i < 4; i++) begin
      mem[i]   = a[8*i +: 8];
      mem[4+i] = b[8*i +: 8];
      mem[8+i] = c[8*i +: 8];
    end
  endtask

  // driver: called at a negedge; accepting edge is cyc+1, valid seen at cyc+13
  task automatic do_read(input logic [31:0] a, b, c);
    load(a, b, c);
    exp_q.push_back(vote(a, b, c));
    exp_cyc_q.push_back(cyc + 13);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy || exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: result word (R4, R8), latency (R5), address walk (R2)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (busy) begin
        if (arr_addr != AW'(fetch_pos)) begin
          n_bad++;
          $display("FAIL R2 actual=%0d expected=%0d", arr_addr, fetch_pos);
        end
        fetch_pos = (fetch_pos == 11) ? 0 : fetch_pos + 1;
      end
      if (rd_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected valid", rd_data, 32'h0);
        end else begin
          logic [31:0] e;
          int ec;
          e  = exp_q.pop_front();
          ec = exp_cyc_q.pop_front();
          check(rd_data === e, "R4/R8 voted word", rd_data, e);
          check(cyc == ec, "R5 latency", 32'(cyc), 32'(ec));
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    for (int i = 0; i < 12; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy === 1'b0, "R1 busy", 32'(busy), 32'h0);
    check(rd_valid === 1'b0, "R1 valid", 32'(rd_valid), 32'h0);
    check(rd_data === 32'h0, "R1 data", rd_data, 32'h0);
    check(arr_addr === '0, "R1 addr", 32'(arr_addr), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 identical copies
    do_read(32'hdeadbeef, 32'hdeadbeef, 32'hdeadbeef); wait_idle();
    // R3 byte order: distinct ascending bytes, identical copies
    do_read(32'h04030201, 32'h04030201, 32'h04030201); wait_idle();
    // R3 copy boundaries: copy 2 outvoted
    do_read(32'h13572468, 32'h13572468, 32'h0badf00d); wait_idle();
    // R8 single corrupted copy, each position
    do_read(~32'h5a5a00ff, 32'h5a5a00ff, 32'h5a5a00ff); wait_idle();
    do_read(32'h5a5a00ff, ~32'h5a5a00ff, 32'h5a5a00ff); wait_idle();
    do_read(32'h5a5a00ff, 32'h5a5a00ff, ~32'h5a5a00ff); wait_idle();
    // R4 all eight bit combinations
    do_read(32'hf0f0f0f0, 32'hcccccccc, 32'haaaaaaaa); wait_idle();
    do_read(32'hffffffff, 32'h00000000, 32'h12345678); wait_idle();

    // R6 requests during a fetch are ignored
    do_read(32'h11112222, 32'h11112222, 32'h33334444);
    repeat (3) @(negedge clk);
    req = 1'b1; @(negedge clk); req = 1'b0;
    repeat (4) @(negedge clk);
    req = 1'b1; @(negedge clk); req = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R6 no extra fetch", 32'(busy), 32'h0);

    // R7 write access ignored; R9 data held
    held = rd_data;
    req = 1'b1; we = 1'b1;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    check(busy === 1'b0, "R7 busy", 32'(busy), 32'h0);
    check(rd_valid === 1'b0, "R7 valid", 32'(rd_valid), 32'h0);
    repeat (5) @(negedge clk);
    check(rd_data === held, "R7/R9 data held", rd_data, held);

    // back-to-back: request in the valid cycle
    do_read(32'hcafef00d, 32'hcafef00d, 32'h00000000);
    while (!rd_valid) @(negedge clk);
    do_read(32'h0f0f0f0f, 32'h0f0f0f0f, 32'h0f0f0f0f);
    wait_idle();

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule